// File: doc/BRIEF.md
# Programmable Tick Timer with Reload

This block is an 8-bit programmable timer on a CPU register bus. A 16-bit prescaler runs on every system clock. Its upper byte can be read as a divider value. A timer counter advances on ticks taken from the prescaler. The tick rate is one of four, selected by a two-bit code in a control register. A control bit starts and stops the counting.

When the counter passes 0xFF it wraps to the value held in a separate reload register. On that wrap it raises a request bit in an interrupt-flag register. The bit stays set until software clears it. The CPU reads and writes all five registers through one byte-wide port. Reads are combinational.

Top module: `prog_tick_timer`

## Requirements
- R1: After a synchronous active-high reset, the prescaler, counter, reload and control registers are zero, and the request flag is clear.
- R2: Address 0xFF04 reads bits 15:8 of the prescaler, which increments by one every clock. Any write to 0xFF04 clears all 16 prescaler bits at that edge.
- R3: Control bit 2 enables counting. While it is 0 the counter (0xFF05) holds its value unless the CPU writes it.
- R4: Control bits 1:0 select the tick period in system clocks: code 0 → 1024, code 1 → 16, code 2 → 64, code 3 → 256. A tick occurs on the edge where the prescaler's low log2(period) bits are all ones.
- R5: A tick while the counter holds 0xFF loads the reload register (0xFF06) into the counter at that same edge.
- R6: That wrap sets bit 2 of the flag register (0xFF0F). The bit stays set until a write with bit 2 equal to 0. A wrap in the same cycle as such a write leaves it set. Writing 1 to bit 2 sets it.
- R7: A CPU write to 0xFF05 in a wrap cycle takes priority: the counter takes the written value and the flag is not set by that wrap.
- R8: 0xFF07 reads bits 7:3 as 1 and bits 2:0 as the control field. 0xFF0F reads bits 7:5 as 1, bits 4:3 and 1:0 as 0, and bit 2 as the flag. Any other address reads 0xFF and writes to it change nothing.
- R9: Output `timer_irq` always equals flag bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| timer_irq | output | 1 | Timer interrupt request (flag bit 2) |

## Verification
The embedded assertions check several properties on every cycle:
- the prescaler steps by one unless cleared;
- the counter holds while disabled;
- a tick always coincides with ones in the prescaler's low bits;
- a wrap loads the reload value and sets the flag;
- a counter write always lands.

Some behaviours show only through the bench's scenarios, which a behavioural model checks every cycle:
- the exact tick period for each of the four rate codes;
- the read formats with their forced-one bits;
- a divider write restarting the tick phase;
- a counter write that collides with a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 16;

    localparam logic [15:0] ADDR_DIV = 16'hFF04;
    localparam logic [15:0] ADDR_CNT = 16'hFF05;
    localparam logic [15:0] ADDR_MOD = 16'hFF06;
    localparam logic [15:0] ADDR_CTL = 16'hFF07;
    localparam logic [15:0] ADDR_IFL = 16'hFF0F;

    // position of the timer request inside the flag register
    localparam int IRQ_POS = 2;

    typedef enum logic [1:0] {
        RATE_DIV1024 = 2'd0,
        RATE_DIV16   = 2'd1,
        RATE_DIV64   = 2'd2,
        RATE_DIV256  = 2'd3
    } rate_e;

    typedef struct packed {
        logic  run;
        rate_e rate;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_DIV, SEL_CNT, SEL_MOD, SEL_CTL, SEL_IFL, SEL_NONE
    } sel_e;

    function automatic int rate_log2(input int code);
        case (code)
            0:       return 10;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

    function automatic sel_e decode(input logic [15:0] a);
        case (a)
            ADDR_DIV: return SEL_DIV;
            ADDR_CNT: return SEL_CNT;
            ADDR_MOD: return SEL_MOD;
            ADDR_CTL: return SEL_CTL;
            ADDR_IFL: return SEL_IFL;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = tmr_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] pre
);
    always_ff @(posedge clk) begin
        if (rst || clr) pre <= '0;
        else            pre <= pre + 1'b1;
    end

    // R2
    pre_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> pre == $past(pre) + 1'b1);
endmodule

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
    parameter int W = tmr_pkg::PRE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   pre,
    input  tmr_pkg::ctrl_t ctrl,
    output logic           tick
);
    logic [3:0] hit;

    for (genvar g = 0; g < 4; g++) begin : g_rate
        localparam int LG = tmr_pkg::rate_log2(g);
        assign hit[g] = &pre[LG-1:0];
    end

    assign tick = ctrl.run & hit[ctrl.rate];

    // R4: every rate period is a multiple of 16 clocks
    tick_phase_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (pre[3:0] == 4'hF));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = tmr_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_top;
    assign at_top = &cnt;
    assign wrap   = tick & at_top & ~wr_en;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_en) cnt <= wr_data;
        else if (wrap)  cnt <= reload;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(cnt));
    // R5
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == $past(reload));
    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt == $past(wr_data));
endmodule

// File: rtl/prog_tick_timer.sv
module prog_tick_timer (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        timer_irq
);
    import tmr_pkg::*;

    localparam int W = DATA_W;

    sel_e              sel;
    logic              wr_div, wr_cnt, wr_mod, wr_ctl, wr_ifl;
    logic [PRE_W-1:0]  pre;
    logic [W-1:0]      cnt, reload_q;
    ctrl_t             ctrl_q;
    logic              flag_q, tick, wrap;

    assign sel    = decode(bus_addr);
    assign wr_div = bus_wr && sel == SEL_DIV;
    assign wr_cnt = bus_wr && sel == SEL_CNT;
    assign wr_mod = bus_wr && sel == SEL_MOD;
    assign wr_ctl = bus_wr && sel == SEL_CTL;
    assign wr_ifl = bus_wr && sel == SEL_IFL;

    tmr_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .clr(wr_div), .pre(pre)
    );

    tmr_rate_sel #(.W(PRE_W)) u_rate (
        .clk(clk), .rst(rst), .pre(pre), .ctrl(ctrl_q), .tick(tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
        .wr_en(wr_cnt), .wr_data(bus_wdata), .reload(reload_q),
        .cnt(cnt), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_mod) reload_q <= bus_wdata;
            if (wr_ctl) ctrl_q   <= ctrl_t'(bus_wdata[2:0]);
            if (wrap)        flag_q <= 1'b1;
            else if (wr_ifl) flag_q <= bus_wdata[IRQ_POS];
        end
    end

    always_comb begin
        case (sel)
            SEL_DIV: bus_rdata = pre[PRE_W-1 -: W];
            SEL_CNT: bus_rdata = cnt;
            SEL_MOD: bus_rdata = reload_q;
            SEL_CTL: bus_rdata = {{(W-3){1'b1}}, ctrl_q};
            SEL_IFL: bus_rdata = {{(W-5){1'b1}}, 2'b00, flag_q, 2'b00};
            default: bus_rdata = '1;
        endcase
    end

    assign timer_irq = flag_q;

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> timer_irq);
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wr_ifl) |=> timer_irq);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!timer_irq && pre == '0 && cnt == '0));
endmodule

// File: tb/prog_tick_timer_tb_top.sv
module prog_tick_timer_tb_top;
    logic        clk = 0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        timer_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prog_tick_timer dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
    );

    // behavioural reference state
    int m_pre, m_cnt, m_mod, m_ctl, m_flag;

    function automatic int m_period();
        case (m_ctl & 3)
            0: return 1024;
            1: return 16;
            2: return 64;
            default: return 256;
        endcase
    endfunction

    function automatic bit m_tick();
        return ((m_ctl >> 2) & 1) == 1 && (m_pre % m_period()) == m_period() - 1;
    endfunction

    function automatic int m_read(input int a);
        case (a)
            16'hFF04: return m_pre >> 8;
            16'hFF05: return m_cnt;
            16'hFF06: return m_mod;
            16'hFF07: return 8'hF8 | m_ctl;
            16'hFF0F: return 8'hE0 | (m_flag << 2);
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            16'hFF04: return "R2";
            16'hFF05: return "R5";
            16'hFF06: return "R5";
            16'hFF07: return "R8";
            16'hFF0F: return "R6";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic cyc(input int a, input bit wr, input int d);
        bit tk, wrp, wc;
        bus_addr = 16'(a); bus_wr = wr; bus_wdata = 8'(d);
        #1;
        check(tag_of(a), int'(bus_rdata), m_read(a));
        check("R9", int'(timer_irq), m_flag);
        @(posedge clk);
        tk  = m_tick();
        wc  = wr && a == 16'hFF05;
        wrp = tk && m_cnt == 255 && !wc;
        if (wc)       m_cnt = d & 255;
        else if (wrp) m_cnt = m_mod;
        else if (tk)  m_cnt = m_cnt + 1;
        if (wrp) m_flag = 1;
        else if (wr && a == 16'hFF0F) m_flag = (d >> 2) & 1;
        if (wr && a == 16'hFF06) m_mod = d & 255;
        if (wr && a == 16'hFF07) m_ctl = d & 7;
        if (wr && a == 16'hFF04) m_pre = 0;
        else m_pre = (m_pre + 1) % 65536;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input int a);
        for (int i = 0; i < n; i++) cyc(a, 0, 0);
    endtask

    initial begin
        #900us;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; bus_addr = 16'h0; bus_wr = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_pre = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_flag = 0;
        // R1 reset values
        check("R1", int'(timer_irq), 0);
        cyc(16'hFF05, 0, 0);
        cyc(16'hFF07, 0, 0);
        cyc(16'hFF0F, 0, 0);
        // R2 divider runs, write clears it
        idle(600, 16'hFF04);
        cyc(16'hFF04, 1, 8'h5A);
        idle(300, 16'hFF04);
        // R3 disabled counter holds
        cyc(16'hFF05, 1, 8'h10);
        idle(100, 16'hFF05);
        // R4/R5/R6 fast rate with wrap
        cyc(16'hFF06, 1, 8'h80);
        cyc(16'hFF05, 1, 8'hFC);
        cyc(16'hFF07, 1, 8'h05);
        idle(200, 16'hFF05);
        check("R6", int'(timer_irq), 1);
        idle(20, 16'hFF0F);
        cyc(16'hFF0F, 1, 8'hFB);   // R6 clear
        check("R6", int'(timer_irq), 0);
        // R4 other rates
        cyc(16'hFF07, 1, 8'h06);
        idle(1500, 16'hFF05);
        cyc(16'hFF07, 1, 8'h07);
        idle(3000, 16'hFF05);
        cyc(16'hFF07, 1, 8'h04);
        cyc(16'hFF05, 1, 8'hFD);
        idle(4000, 16'hFF05);
        // R3 stop mid-run
        cyc(16'hFF07, 1, 8'h01);
        idle(300, 16'hFF05);
        // R7 collide a counter write with a wrap
        cyc(16'hFF0F, 1, 8'h00);
        cyc(16'hFF06, 1, 8'h33);
        cyc(16'hFF05, 1, 8'hFF);
        cyc(16'hFF07, 1, 8'h05);
        for (int i = 0; i < 100 && !(m_tick() && m_cnt == 255); i++) cyc(16'hFF05, 0, 0);
        cyc(16'hFF05, 1, 8'h44);
        check("R7", int'(bus_rdata), 8'h44);
        check("R7", int'(timer_irq), 0);
        idle(40, 16'hFF0F);
        // R6 write 1 sets, wrap beats clearing write
        cyc(16'hFF0F, 1, 8'h04);
        check("R6", int'(timer_irq), 1);
        cyc(16'hFF0F, 1, 8'h00);
        cyc(16'hFF05, 1, 8'hFF);
        for (int i = 0; i < 100 && !(m_tick() && m_cnt == 255); i++) cyc(16'hFF0F, 0, 0);
        cyc(16'hFF0F, 1, 8'h00);
        check("R6", int'(timer_irq), 1);
        // R8 unmapped address
        cyc(16'h1234, 1, 8'h00);
        cyc(16'hFF08, 0, 0);
        idle(20, 16'hFF07);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule